// File: doc/BRIEF.md
# Min-Sum Check Node Update Unit

This block performs the check-side update of a min-sum low-density parity-check decoder for one parity row with `WR` connected edges. On a cycle where `in_valid` is high it takes `WR` incoming variable-to-check messages in sign-magnitude form. One cycle later it presents `WR` outgoing check-to-variable messages together with `out_valid`.

Each outgoing message excludes its own edge. Its sign is the product of the other edges' signs, formed as the XOR of all sign bits with the edge's own sign removed. Its magnitude is the smallest of the other edges' magnitudes, multiplied by a fixed factor.

The design avoids a separate minimum search per edge. A comparator tree of depth log2(`WR`) finds the smallest magnitude, the second smallest, and the position of the smallest. Every edge then picks one of the two values. The scaling factor is `SCALE_QTR`/4, with `SCALE_QTR` set to 4, 3 or 2. The product is truncated toward zero.

Top module: `minsum_check_node`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `out_msg` is all zeros.
- R2: `out_valid` is high exactly in the cycle after `in_valid` was high. When `in_valid` is low, `out_msg` keeps its previous value.
- R3: Edge i occupies bits `[i*5 +: 5]` of `in_msg` and `out_msg`. Bit 4 of each lane is the sign, and 1 means negative. The output sign of edge i is the XOR of the sign bits of all other input lanes.
- R4: The output magnitude of edge i is floor(m * `SCALE_QTR` / 4), where m is the smallest magnitude among all input lanes other than i. The magnitude is bits 3:0 of a lane.
- R5: When two or more lanes share the smallest magnitude, every edge, including each tied edge, receives that smallest magnitude before scaling.
- R6: With the default `SCALE_QTR` = 3, a pre-scale magnitude of 15 yields 11 and a magnitude of 1 yields 0. The scaling is truncation, not rounding.
- R7: Inputs on consecutive cycles produce results on consecutive cycles, in order, with no lost updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input message set is valid this cycle |
| in_msg | input | WR*5 | Variable-to-check messages, one 5-bit sign-magnitude lane per edge |
| out_valid | output | 1 | Output message set is valid |
| out_msg | output | WR*5 | Check-to-variable messages, same lane layout |

## Verification
The embedded properties assume that `in_valid` and `in_msg` are known, meaning free of X, on every clock edge after reset. They also assume that `WR` is at least 2, so the tree always has a real second candidate. The driver holds both inputs at defined values at all times and parks `in_valid` low between bursts. The vectors cover distinct minima at the first and last edges, ties at the minimum, all-equal and all-zero rows, saturated magnitudes and negative zero. They finish with a back-to-back burst of random rows.

// File: rtl/minsum_check_node.sv
module minsum_check_node #(
  parameter int WR        = 4,
  parameter int MSG_W     = 5,
  parameter int SCALE_QTR = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [WR*MSG_W-1:0] in_msg,
  output logic                out_valid,
  output logic [WR*MSG_W-1:0] out_msg
);
  localparam int MAG_W  = MSG_W - 1;
  localparam int LVL    = $clog2(WR);
  localparam int LEAVES = 1 << LVL;
  localparam int IDX_W  = (LVL > 0) ? LVL : 1;
  localparam bit EVEN   = (WR % 2) == 0;

  logic [2*LEAVES-1:0][MAG_W-1:0] t_m1, t_m2;
  logic [2*LEAVES-1:0][IDX_W-1:0] t_ix;
  logic [WR-1:0]                  sgn;
  logic                           parity;
  logic [MAG_W+2:0]               p1, p2;
  logic [MAG_W-1:0]               s1, s2;
  logic [WR*MSG_W-1:0]            nxt;

  assign t_m1[0] = '0;
  assign t_m2[0] = '0;
  assign t_ix[0] = '0;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < WR) begin : g_real
      assign t_m1[LEAVES+i] = in_msg[i*MSG_W +: MAG_W];
      assign sgn[i]         = in_msg[i*MSG_W + MAG_W];
    end else begin : g_pad
      assign t_m1[LEAVES+i] = '1;
    end
    assign t_m2[LEAVES+i] = '1;
    assign t_ix[LEAVES+i] = IDX_W'(i);
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_l;
    assign take_l  = t_m1[2*n] <= t_m1[2*n+1];
    assign t_m1[n] = take_l ? t_m1[2*n] : t_m1[2*n+1];
    assign t_ix[n] = take_l ? t_ix[2*n] : t_ix[2*n+1];
    assign t_m2[n] = take_l
      ? ((t_m2[2*n]   < t_m1[2*n+1]) ? t_m2[2*n]   : t_m1[2*n+1])
      : ((t_m2[2*n+1] < t_m1[2*n])   ? t_m2[2*n+1] : t_m1[2*n]);
  end

  assign parity = ^sgn;
  assign p1 = {3'b000, t_m1[1]} * (MAG_W+3)'(SCALE_QTR);
  assign p2 = {3'b000, t_m2[1]} * (MAG_W+3)'(SCALE_QTR);
  assign s1 = p1[MAG_W+1:2];
  assign s2 = p2[MAG_W+1:2];

  for (genvar i = 0; i < WR; i++) begin : g_out
    assign nxt[i*MSG_W + MAG_W]  = parity ^ sgn[i];
    assign nxt[i*MSG_W +: MAG_W] = (t_ix[1] == IDX_W'(i)) ? s2 : s1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_msg <= nxt;
    end
  end

  logic [WR-1:0] out_sgn;
  for (genvar i = 0; i < WR; i++) begin : g_osgn
    assign out_sgn[i] = out_msg[i*MSG_W + MAG_W];
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_msg));
  a_r3_sign_parity: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((^out_sgn) == ($past(parity) & EVEN)));
  a_r5_min_order: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (t_m2[1] >= t_m1[1]) && (int'(t_ix[1]) < WR));
endmodule

// File: tb/minsum_check_node_bench.sv
module minsum_check_node_bench;
  localparam int WR = 4;
  localparam int MW = 5;
  localparam int SQ = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [WR*MW-1:0]  in_msg = '0;
  logic              out_valid;
  logic [WR*MW-1:0]  out_msg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [WR*MW-1:0] exp_q[$];
  string            tag_q[$];

  always #10 clk = ~clk;

  minsum_check_node #(.WR(WR), .MSG_W(MW), .SCALE_QTR(SQ)) u_minsum_check_node (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(out_valid), .out_msg(out_msg)
  );

  function automatic logic [WR*MW-1:0] model(input logic [WR*MW-1:0] v);
    logic [WR*MW-1:0] r;
    for (int i = 0; i < WR; i++) begin
      int m = 99;
      logic s = 1'b0;
      for (int j = 0; j < WR; j++) begin
        if (j != i) begin
          s ^= v[j*MW + MW-1];
          if (int'(v[j*MW +: MW-1]) < m) m = int'(v[j*MW +: MW-1]);
        end
      end
      r[i*MW + MW-1]  = s;
      r[i*MW +: MW-1] = 4'((m * SQ) / 4);
    end
    return r;
  endfunction

  function automatic logic [MW-1:0] lane(input bit neg, input int mag);
    return {neg, 4'(mag)};
  endfunction

  task automatic drive(input logic [WR*MW-1:0] v, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_msg   = v;
    exp_q.push_back(model(v));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [WR*MW-1:0] act, input logic [WR*MW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected out_valid", out_msg, '0);
      end else begin
        logic [WR*MW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        for (int i = 0; i < WR; i++) begin
          check(out_msg[i*MW + MW-1] == e[i*MW + MW-1], {t, " R3 sign"}, out_msg, e);
          check(out_msg[i*MW +: MW-1] == e[i*MW +: MW-1], {t, " R4 magnitude"}, out_msg, e);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [WR*MW-1:0] last;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_msg == '0, "R1 reset state", out_msg, '0);
    in_valid = 1'b1;
    in_msg = {lane(1,3), lane(0,7), lane(1,2), lane(0,9)};
    @(negedge clk);
    check(out_valid == 1'b0 && out_msg == '0, "R1 reset ignores input", out_msg, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_msg == '0, "R1 first cycle after reset", out_msg, '0);

    drive({lane(0,12), lane(0,9), lane(0,5), lane(0,3)}, "min at edge0");
    drive({lane(1,2), lane(0,9), lane(1,6), lane(0,11)}, "min at edge3 mixed signs");
    drive({lane(1,8), lane(1,8), lane(1,8), lane(1,8)}, "R5 all equal");
    drive({lane(0,10), lane(1,4), lane(0,4), lane(1,13)}, "R5 tie at min");
    idle(1);
    drive({lane(0,15), lane(0,15), lane(0,15), lane(1,15)}, "R6 saturated 15->11");
    drive({lane(0,1), lane(0,1), lane(0,14), lane(0,6)}, "R6 small 1->0");
    drive({lane(1,0), lane(0,7), lane(0,5), lane(0,0)}, "zeros and negative zero");
    idle(2);
    check(out_valid == 1'b0, "R2 out_valid drops when idle", {19'b0, out_valid}, '0);
    last = out_msg;
    idle(2);
    check(out_msg == last, "R2 out_msg holds when idle", out_msg, last);

    for (int k = 0; k < 40; k++) begin
      logic [WR*MW-1:0] v;
      v = WR*MW'($urandom());
      drive(v, "R7 back-to-back random");
    end
    idle(4);
    check(exp_q.size() == 0, "R7 all results delivered", WR*MW'(exp_q.size()), '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule